// File: doc/BRIEF.md
# Tap-Alternating Iteration Address Generator

This controller drives the schedule of a decision-directed channel tracker that refines a channel impulse response one tap at a time. After a start pulse it walks through four timed phases: loading the memories, a precompute pass, the tap-update iterations, and writing the taps back. It then signals completion. The controller only produces addresses, enables and the current phase. The sample, residual and tap memories and all arithmetic sit outside it.

During the iterations, each tap update selects a delay tap and a transmit antenna. The receive antennas are interleaved inside each update, so two downstream arithmetic units can work on different receive antennas at once. The delay shift of the decision samples is done only through address arithmetic. Each shifted access is split into a word address and a lane-rotation amount. A run-time feedback divisor shortens the part of each vector that is visited. The iteration and precompute phases shrink in proportion.

Top module: `tap_iter_addrgen`

## Requirements
- R1: After reset, and in idle, `phase` is 0, `done` is 0, every enable is low and every address output is 0.
- R2: Phase codes are idle=0, load=1, precompute=2, iterate=3, write-back=4, finish=5. A run always steps 0→1→2→3→4→5→0. `start` is acted on only in idle and is ignored in every other phase.
- R3: With TAPS=NT·NR·NL and WPF=NK/(W·2^fb_sel), the phase lengths in cycles are: load TAPS; precompute NT·WPF·(1+NL)+2; iterate WPF·NT·NR·NL·NI+5; write-back TAPS+2.
- R4: `fb_sel` (2 bits) selects the divisor 2^fb_sel. It is sampled in the cycle that `start` is accepted. Changes to it during a run have no effect.
- R5: For active iterate cycle u (0-based), the word is k=u mod WPF and the receive antenna is r=(u div WPF) mod NR. With m−1=u div (WPF·NR), the tap is l=(m−1) mod NL and the transmit antenna is i=((m−1) div NL) mod NT.
- R6: In an active iterate cycle, let s=(k·W−l) mod NK. Then `dec_addr`=i·(NK/W)+(s div W), `lane_rot`=s mod W, and `dec_en`=1.
- R7: In an active iterate cycle, `res_addr`=r·(NK/W)+k and `res_en`=1.
- R8: In an active iterate cycle, `tap_addr`=(r·NT+i)·NL+l. `tap_rd_en` is 1 exactly when k=0, and `tap_wr_en` is 1 exactly when k=WPF−1.
- R9: In load cycle c, `tap_wr_en`=1 and `tap_addr`=c. In write-back cycle c with c<TAPS, `tap_rd_en`=1 and `tap_addr`=c.
- R10: In precompute, in the last 5 iterate cycles and in the last 2 write-back cycles, all enables are low. Any address or rotation output whose enable is low reads 0.
- R11: `done` is 1 only in the single finish cycle that directly follows the last write-back cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (accepted in idle only) |
| fb_sel | input | 2 | Feedback divisor exponent |
| phase | output | 3 | Current phase code |
| done | output | 1 | One-cycle completion pulse |
| dec_en | output | 1 | Decision-sample memory access |
| dec_addr | output | $clog2(NT·NK/W) | Decision-sample word address |
| lane_rot | output | $clog2(W) | Lane rotation for the unaligned shifted word |
| res_en | output | 1 | Residual memory access |
| res_addr | output | $clog2(NR·NK/W) | Residual word address |
| tap_rd_en | output | 1 | Tap memory read |
| tap_wr_en | output | 1 | Tap memory write |
| tap_addr | output | $clog2(NT·NR·NL) | Tap memory address |

## Verification
All outputs are decoded without a register from the phase and loop counters. So the cycle after the clock edge that accepts `start` is load cycle 0. From there, every address, enable and phase value is due in the same cycle as the counter state that produces it. The bench counts cycles from that first load cycle and computes the expected output for each cycle from the phase lengths and index formulas. It samples at the falling edge, half a cycle after each update, and compares every output in every cycle up to the return to idle. The start pulse and the `fb_sel` change made mid-run are applied at a falling edge. Their absence of effect is checked in every following cycle of that run.

// File: rtl/tia_pkg.sv
// Shared phase encoding for the tap-alternating iteration address generator.
package tia_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LOAD = 3'd1,
        ST_PRE  = 3'd2,
        ST_ITER = 3'd3,
        ST_WB   = 3'd4,
        ST_FIN  = 3'd5
    } phase_e;
endpackage

// File: rtl/tia_phase_ctrl.sv
// Phase sequencer: steps idle->load->precompute->iterate->write-back->finish,
// times each phase from the parameters and the divisor latched at start.
// Assumes NK/W is a power of two and at least 2^(max fb_sel).
module tia_phase_ctrl
    import tia_pkg::*;
#(
    parameter int NT  = 2,
    parameter int NR  = 2,
    parameter int NL  = 4,
    parameter int NK  = 32,
    parameter int NI  = 2,
    parameter int W   = 4,
    parameter int FBW = 2,
    parameter int CW  = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [FBW-1:0] fb_sel,
    output phase_e         state,
    output logic [CW-1:0]  cnt,
    output logic [FBW-1:0] fb_q,
    output logic           iter_act
);
    localparam int WPN  = NK / W;
    localparam int TAPS = NT * NR * NL;

    int wpf, pre_len, it_len, wb_len, cur_len;
    phase_e nxt;

    // Phase lengths for the latched divisor and the successor of each phase.
    always_comb begin
        wpf     = WPN >> fb_q;
        pre_len = NT * wpf * (1 + NL) + 2;
        it_len  = wpf * NT * NR * NL * NI + 5;
        wb_len  = TAPS + 2;
        case (state)
            ST_LOAD: begin cur_len = TAPS;    nxt = ST_PRE;  end
            ST_PRE:  begin cur_len = pre_len; nxt = ST_ITER; end
            ST_ITER: begin cur_len = it_len;  nxt = ST_WB;   end
            ST_WB:   begin cur_len = wb_len;  nxt = ST_FIN;  end
            default: begin cur_len = 1;       nxt = ST_IDLE; end
        endcase
    end

    // Active iterate cycles are all but the final pipeline-drain gap.
    assign iter_act = (state == ST_ITER) && (int'(cnt) < it_len - 5);

    // State, in-phase cycle counter and divisor capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            fb_q  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_LOAD;
                        fb_q  <= fb_sel;
                        cnt   <= '0;
                    end
                end
                ST_FIN: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
                default: begin
                    if (int'(cnt) == cur_len - 1) begin
                        state <= nxt;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/tia_iter_cnt.sv
// Nested iteration counters: word (innermost), receive antenna, tap,
// transmit antenna. Cleared outside the iterate phase, advanced per step.
module tia_iter_cnt #(
    parameter int NT  = 2,
    parameter int NR  = 2,
    parameter int NL  = 4,
    parameter int KW  = 4,
    parameter int RW  = 2,
    parameter int LLW = 3,
    parameter int IW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           step,
    input  logic [KW-1:0]  k_last,
    output logic [KW-1:0]  k,
    output logic [RW-1:0]  r,
    output logic [LLW-1:0] l,
    output logic [IW-1:0]  i
);
    // Advance word, then receive antenna, then tap, then transmit antenna.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            k <= '0;
            r <= '0;
            l <= '0;
            i <= '0;
        end else if (step) begin
            if (k == k_last) begin
                k <= '0;
                if (int'(r) == NR - 1) begin
                    r <= '0;
                    if (int'(l) == NL - 1) begin
                        l <= '0;
                        i <= (int'(i) == NT - 1) ? '0 : i + 1'b1;
                    end else begin
                        l <= l + 1'b1;
                    end
                end else begin
                    r <= r + 1'b1;
                end
            end else begin
                k <= k + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tia_addr_map.sv
// Combinational address decode: linear tap addressing in load and
// write-back, cyclically shifted sample addressing in iterate.
// Assumes NK and W are powers of two so the shift wraps by truncation.
module tia_addr_map
    import tia_pkg::*;
#(
    parameter int NT  = 2,
    parameter int NR  = 2,
    parameter int NL  = 4,
    parameter int NK  = 32,
    parameter int W   = 4,
    parameter int CW  = 10,
    parameter int KW  = 4,
    parameter int RW  = 2,
    parameter int LLW = 3,
    parameter int IW  = 2,
    parameter int LW  = 2,
    parameter int DAW = 4,
    parameter int RAW = 4,
    parameter int TAW = 4
) (
    input  phase_e         state,
    input  logic [CW-1:0]  cnt,
    input  logic           iter_act,
    input  logic [KW-1:0]  k,
    input  logic [RW-1:0]  r,
    input  logic [LLW-1:0] l,
    input  logic [IW-1:0]  i,
    input  logic [KW-1:0]  k_last,
    output logic           dec_en,
    output logic [DAW-1:0] dec_addr,
    output logic [LW-1:0]  lane_rot,
    output logic           res_en,
    output logic [RAW-1:0] res_addr,
    output logic           tap_rd_en,
    output logic           tap_wr_en,
    output logic [TAW-1:0] tap_addr
);
    localparam int WPN  = NK / W;
    localparam int LNK  = $clog2(NK);
    localparam int TAPS = NT * NR * NL;

    logic [LNK-1:0] sidx;

    // Shifted sample index wraps modulo NK through truncation.
    assign sidx = LNK'(int'(k) * W - int'(l));

    // Per-phase address and enable decode; unused outputs held at zero.
    always_comb begin
        dec_en    = 1'b0;
        dec_addr  = '0;
        lane_rot  = '0;
        res_en    = 1'b0;
        res_addr  = '0;
        tap_rd_en = 1'b0;
        tap_wr_en = 1'b0;
        tap_addr  = '0;
        case (state)
            ST_LOAD: begin
                tap_wr_en = 1'b1;
                tap_addr  = TAW'(cnt);
            end
            ST_ITER: begin
                if (iter_act) begin
                    dec_en    = 1'b1;
                    dec_addr  = DAW'(int'(i) * WPN + int'(sidx >> LW));
                    lane_rot  = sidx[LW-1:0];
                    res_en    = 1'b1;
                    res_addr  = RAW'(int'(r) * WPN + int'(k));
                    tap_rd_en = (k == '0);
                    tap_wr_en = (k == k_last);
                    tap_addr  = TAW'((int'(r) * NT + int'(i)) * NL + int'(l));
                end
            end
            ST_WB: begin
                if (int'(cnt) < TAPS) begin
                    tap_rd_en = 1'b1;
                    tap_addr  = TAW'(cnt);
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tap_iter_addrgen.sv
// Top: sequences load, precompute, tap-alternating iterations and
// write-back, and emits memory addresses for each. Outputs are decoded
// from the counter state in the same cycle (no output register).
module tap_iter_addrgen
    import tia_pkg::*;
#(
    parameter int NT  = 2,
    parameter int NR  = 2,
    parameter int NL  = 4,
    parameter int NK  = 32,
    parameter int NI  = 2,
    parameter int W   = 4,
    parameter int FBW = 2,
    localparam int WPN  = NK / W,
    localparam int TAPS = NT * NR * NL,
    localparam int LW   = $clog2(W),
    localparam int DAW  = $clog2(NT * WPN),
    localparam int RAW  = $clog2(NR * WPN),
    localparam int TAW  = $clog2(TAPS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [FBW-1:0] fb_sel,
    output logic [2:0]     phase,
    output logic           done,
    output logic           dec_en,
    output logic [DAW-1:0] dec_addr,
    output logic [LW-1:0]  lane_rot,
    output logic           res_en,
    output logic [RAW-1:0] res_addr,
    output logic           tap_rd_en,
    output logic           tap_wr_en,
    output logic [TAW-1:0] tap_addr
);
    localparam int MAXLEN = 2 * TAPS + 2 + NT * WPN * (1 + NL) + 2
                          + WPN * NT * NR * NL * NI + 5;
    localparam int CW  = $clog2(MAXLEN + 1);
    localparam int KW  = $clog2(WPN) + 1;
    localparam int RW  = $clog2(NR) + 1;
    localparam int LLW = $clog2(NL) + 1;
    localparam int IW  = $clog2(NT) + 1;

    phase_e         state;
    logic [CW-1:0]  cnt;
    logic [FBW-1:0] fb_q;
    logic           iter_act;
    logic [KW-1:0]  k, k_last;
    logic [RW-1:0]  r;
    logic [LLW-1:0] l;
    logic [IW-1:0]  i;

    // Last word index of each truncated vector.
    assign k_last = KW'((WPN >> fb_q) - 1);
    assign phase  = state;
    assign done   = (state == ST_FIN);

    tia_phase_ctrl #(
        .NT(NT), .NR(NR), .NL(NL), .NK(NK), .NI(NI), .W(W), .FBW(FBW), .CW(CW)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start), .fb_sel(fb_sel),
        .state(state), .cnt(cnt), .fb_q(fb_q), .iter_act(iter_act)
    );

    tia_iter_cnt #(
        .NT(NT), .NR(NR), .NL(NL), .KW(KW), .RW(RW), .LLW(LLW), .IW(IW)
    ) cnt_i (
        .clk(clk), .rst_n(rst_n), .clr(state != ST_ITER), .step(iter_act),
        .k_last(k_last), .k(k), .r(r), .l(l), .i(i)
    );

    tia_addr_map #(
        .NT(NT), .NR(NR), .NL(NL), .NK(NK), .W(W), .CW(CW), .KW(KW), .RW(RW),
        .LLW(LLW), .IW(IW), .LW(LW), .DAW(DAW), .RAW(RAW), .TAW(TAW)
    ) map_i (
        .state(state), .cnt(cnt), .iter_act(iter_act), .k(k), .r(r), .l(l),
        .i(i), .k_last(k_last), .dec_en(dec_en), .dec_addr(dec_addr),
        .lane_rot(lane_rot), .res_en(res_en), .res_addr(res_addr),
        .tap_rd_en(tap_rd_en), .tap_wr_en(tap_wr_en), .tap_addr(tap_addr)
    );
endmodule

// File: rtl/tia_addrgen_chk.sv
// Temporal checks on the address generator, bound to every instance.
module tia_addrgen_chk #(
    parameter int WPN = 8,
    parameter int FBW = 2,
    parameter int RAW = 4,
    parameter int TAW = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [2:0]     st,
    input logic [FBW-1:0] fb_q,
    input logic           done,
    input logic           dec_en,
    input logic           res_en,
    input logic [RAW-1:0] res_addr,
    input logic           tap_rd_en,
    input logic           tap_wr_en,
    input logic [TAW-1:0] tap_addr
);
    a_r2_phase_order: assert property (@(posedge clk) disable iff (!rst_n)
        (st != $past(st)) |->
            ((st == 3'd1 && $past(st) == 3'd0) || (st == 3'd2 && $past(st) == 3'd1) ||
             (st == 3'd3 && $past(st) == 3'd2) || (st == 3'd4 && $past(st) == 3'd3) ||
             (st == 3'd5 && $past(st) == 3'd4) || (st == 3'd0 && $past(st) == 3'd5)));

    a_r4_fb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st != 3'd0 && $past(st) != 3'd0) |-> $stable(fb_q));

    a_r11_done_once: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_done_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(st) == 3'd4));

    a_r10_precompute_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd2) |-> !(dec_en || res_en || tap_rd_en || tap_wr_en));

    a_r8_read_on_first_word: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd3 && tap_rd_en) |-> (int'(res_addr) % WPN == 0));

    a_r9_load_linear: assert property (@(posedge clk) disable iff (!rst_n)
        (st == 3'd1 && $past(st) == 3'd1) |-> (int'(tap_addr) == int'($past(tap_addr)) + 1));
endmodule

bind tap_iter_addrgen tia_addrgen_chk #(
    .WPN(NK / W), .FBW(FBW), .RAW($clog2(NR * (NK / W))), .TAW($clog2(NT * NR * NL))
) chk_i (
    .clk(clk), .rst_n(rst_n), .st(phase), .fb_q(fb_q), .done(done),
    .dec_en(dec_en), .res_en(res_en), .res_addr(res_addr),
    .tap_rd_en(tap_rd_en), .tap_wr_en(tap_wr_en), .tap_addr(tap_addr)
);

// File: tb/tap_iter_addrgen_tb_top.sv
// Cycle-by-cycle bench: every output is predicted arithmetically for every
// cycle of a run, across all feedback divisors and a disturbed run.
module tap_iter_addrgen_tb_top;
    localparam int NT = 2, NR = 2, NL = 4, NK = 32, NI = 2, W = 4;
    localparam int WPN  = NK / W;
    localparam int TAPS = NT * NR * NL;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] fb_sel = 2'd0;
    logic [2:0] phase;
    logic done, dec_en, res_en, tap_rd_en, tap_wr_en;
    logic [$clog2(NT*WPN)-1:0] dec_addr;
    logic [$clog2(W)-1:0] lane_rot;
    logic [$clog2(NR*WPN)-1:0] res_addr;
    logic [$clog2(TAPS)-1:0] tap_addr;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    tap_iter_addrgen #(.NT(NT), .NR(NR), .NL(NL), .NK(NK), .NI(NI), .W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .fb_sel(fb_sel),
        .phase(phase), .done(done), .dec_en(dec_en), .dec_addr(dec_addr),
        .lane_rot(lane_rot), .res_en(res_en), .res_addr(res_addr),
        .tap_rd_en(tap_rd_en), .tap_wr_en(tap_wr_en), .tap_addr(tap_addr)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Expected outputs for cycle t counted from the first load cycle.
    task automatic model(input int f, input int t, output int e[10]);
        int wpf, lp, pp, ip, bp, u, k, r, m1, l, i, s;
        for (int n = 0; n < 10; n++) e[n] = 0;
        wpf = WPN >> f;
        lp = TAPS;
        pp = NT * wpf * (1 + NL) + 2;
        ip = wpf * NT * NR * NL * NI + 5;
        bp = TAPS + 2;
        if (t < lp) begin
            e[0] = 1; e[7] = 1; e[9] = t;
        end else if (t < lp + pp) begin
            e[0] = 2;
        end else if (t < lp + pp + ip) begin
            e[0] = 3;
            u = t - lp - pp;
            if (u < ip - 5) begin
                k  = u % wpf;
                r  = (u / wpf) % NR;
                m1 = u / (wpf * NR);
                l  = m1 % NL;
                i  = (m1 / NL) % NT;
                s  = ((k * W - l) % NK + NK) % NK;
                e[2] = 1; e[3] = i * WPN + s / W; e[4] = s % W;
                e[5] = 1; e[6] = r * WPN + k;
                e[8] = (k == 0); e[7] = (k == wpf - 1);
                e[9] = (r * NT + i) * NL + l;
            end
        end else if (t < lp + pp + ip + bp) begin
            e[0] = 4;
            u = t - lp - pp - ip;
            if (u < TAPS) begin e[8] = 1; e[9] = u; end
        end else if (t == lp + pp + ip + bp) begin
            e[0] = 5; e[1] = 1;
        end
    endtask

    // Compare all outputs against a prediction; tag by the governing requirement.
    task automatic compare(input int e[10]);
        string ta;
        ta = (e[0] == 3) ? "R8" : "R9";
        chk("R3",  "phase",     int'(phase), e[0]);
        chk("R11", "done",      int'(done), e[1]);
        chk("R6",  "dec_en",    int'(dec_en), e[2]);
        chk("R6",  "dec_addr",  int'(dec_addr), e[3]);
        chk("R6",  "lane_rot",  int'(lane_rot), e[4]);
        chk("R7",  "res_en",    int'(res_en), e[5]);
        chk("R7",  "res_addr",  int'(res_addr), e[6]);
        chk(ta,    "tap_wr_en", int'(tap_wr_en), e[7]);
        chk(ta,    "tap_rd_en", int'(tap_rd_en), e[8]);
        chk(ta,    "tap_addr",  int'(tap_addr), e[9]);
    endtask

    // One full run; with disturb, start and fb_sel are toggled mid-iterate (R2, R4).
    task automatic run(input int f, input bit disturb);
        int e[10];
        int last, poke;
        int wpf;
        wpf  = WPN >> f;
        last = TAPS + (NT * wpf * (1 + NL) + 2) + (wpf * NT * NR * NL * NI + 5) + TAPS + 2 + 1;
        poke = TAPS + NT * wpf * (1 + NL) + 2 + 3;
        @(negedge clk);
        start  = 1'b1;
        fb_sel = 2'(f);
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t <= last; t++) begin
            model(f, t, e);
            compare(e);
            start = 1'b0;
            if (disturb && (t == poke || t == 2)) begin
                start  = 1'b1;
                fb_sel = ~2'(f);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        int e[10];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle state after reset
        for (int n = 0; n < 10; n++) e[n] = 0;
        chk("R1", "idle phase", int'(phase), 0);
        chk("R1", "idle enables", int'({dec_en, res_en, tap_rd_en, tap_wr_en, done}), 0);
        chk("R1", "idle addrs", int'(dec_addr) + int'(res_addr) + int'(tap_addr) + int'(lane_rot), 0);
        // R4 R5: all divisors, full-rate run disturbed for R2
        run(0, 1'b1);
        run(1, 1'b0);
        run(2, 1'b0);
        run(3, 1'b1);
        run(0, 1'b0);
        // R10: quiet idle after the last run
        compare(e);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #3_000_000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule